// File: doc/BRIEF.md
# Byte-sliced AES encryption engine

This block encrypts one 128-bit block with AES under a 128-, 192- or 256-bit cipher key. Instead of computing a whole round per clock, the state is walked column by column through a narrow datapath that handles `LANES` state bytes per clock. `LANES` is 2 or 4 and is fixed at elaboration. Every key addition, including the initial whitening, takes a fixed 16/`LANES` cycles. A block therefore takes (Nr+1)·16/`LANES` cycles, and the throughput is `LANES`·f_clk/(Nr+1) bytes per second.

A caller presents the key, a key-length code and the plaintext, then pulses `start` for one cycle. Round keys are produced one word at a time inside the block, from a sliding window of the most recent Nk key words, at the moment each column needs them. When the last column of the last round has been written, `done` pulses once and `ct` carries the ciphertext. `ct` keeps that value until the next accepted start.

Top module: `aes_slice_enc`

## Requirements
- R1: After reset, `ct` is all zeros and `done` is low.
- R2: `key_len` selects the key size. Code 00 selects 128 bits with Nr=10 and uses `key[255:128]`. Code 01 selects 192 bits with Nr=12 and uses `key[255:64]`. Codes 10 and 11 both select 256 bits with Nr=14. Key bits below the selected size have no effect. Key byte 0 is `key[255:248]`.
- R3: Plaintext byte i is `pt[127-8i -: 8]` and sits at state row i mod 4, column i div 4. Ciphertext bytes are laid out in `ct` the same way.
- R4: `ct` is the AES encryption of `pt`. The sequence is: an initial round-key XOR; then Nr-1 rounds of S-box substitution, row shift (row r rotated left by r bytes), column mixing by the circulant matrix {02,03,01,01} over GF(2^8) mod 0x11B, and round-key XOR; then a last round that has no column mixing. The S-box is the field inverse followed by the affine map, with 00 mapping to 63.
- R5: Round keys follow the standard Rijndael key schedule for all three key sizes. The known-answer results for 128-, 192- and 256-bit keys are met.
- R6: `done` is high in the cycle that follows the (Nr+1)·16/`LANES`-th rising edge after the edge that accepted `start`.
- R7: `done` is high for exactly one cycle per block. The final ciphertext is on `ct` in that same cycle.
- R8: While the block is idle, `ct` holds its value until the next accepted `start`.
- R9: A `start` pulse that arrives while a block is in progress is ignored. This includes its key, key length and plaintext.
- R10: `LANES`=2 and `LANES`=4 produce identical ciphertext for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a block; accepted only when idle |
| key_len | input | 2 | Key size code (00:128, 01:192, 1x:256) |
| key | input | 256 | Cipher key, byte 0 in the top bits |
| pt | input | 128 | Plaintext block, byte 0 in the top bits |
| ct | output | 128 | Ciphertext block, byte 0 in the top bits |
| done | output | 1 | One-cycle pulse when `ct` is final |

## Verification
The 4-lane block's result is due 4·(Nr+1) edges after the accepted start: 44, 52 or 60 edges. The 2-lane block's result is due 8·(Nr+1) edges after the accepted start: 88, 104 or 120 edges. Both instances run side by side from the same stimulus. The bench drives inputs and samples outputs on falling edges. It records the first falling edge at which each `done` is seen and compares that index with the count expected for the key size, plus one for the half cycle. It takes the ciphertext at that same point and then samples `ct` again several idle cycles later. It counts every cycle in which `done` is high, so the pulse must be exactly one cycle wide. A second start, with different data, is pushed in the fourth cycle of a block, while both instances are still busy, and the block must still finish on time with the first block's result.

// File: rtl/aes_slice_pkg.sv
`timescale 1ns/1ps
package aes_slice_pkg;

  // GF(2^8) doubling, reduction polynomial 0x11B
  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // inverse as a^254 (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] e3, e7, e15, e31, e63, e127;
    e3   = gmul(gmul(a, a), a);
    e7   = gmul(gmul(e3, e3), a);
    e15  = gmul(gmul(e7, e7), a);
    e31  = gmul(gmul(e15, e15), a);
    e63  = gmul(gmul(e31, e31), a);
    e127 = gmul(gmul(e63, e63), a);
    return gmul(e127, e127);
  endfunction

  function automatic logic [7:0] sbox_fn(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  // column word: row 0 in bits [31:24]
  function automatic logic [31:0] mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] r);
    case (r)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  function automatic logic [31:0] rot_word(input logic [31:0] w);
    return {w[23:0], w[31:24]};
  endfunction

  // key words for a key_len code
  function automatic logic [3:0] nk_of(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd4;
      2'b01:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] nr_of(input logic [1:0] code);
    return nk_of(code) + 4'd6;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
`timescale 1ns/1ps
module aes_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import aes_slice_pkg::*;
  assign dout = sbox_fn(din);
endmodule

// File: rtl/aes_key_sched.sv
`timescale 1ns/1ps
module aes_key_sched #(
  parameter int MAXW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [32*MAXW-1:0]  key_in,
  input  logic [1:0]          key_len,
  input  logic                advance,
  output logic [31:0]         word
);
  import aes_slice_pkg::*;
  localparam int IW = $clog2(MAXW);

  logic [31:0] win [MAXW];
  logic [3:0]  nk;
  logic [3:0]  kpos;
  logic [7:0]  rcon;
  logic [31:0] tail, sub_in, sub_out, gen;

  assign tail   = win[IW'(nk - 4'd1)];
  assign sub_in = (kpos == 4'd0) ? rot_word(tail) : tail;

  for (genvar b = 0; b < 4; b++) begin : g_ksub
    aes_sbox u_sbox (.din(sub_in[8*b +: 8]), .dout(sub_out[8*b +: 8]));
  end

  always_comb begin
    if (kpos == 4'd0)
      gen = win[0] ^ sub_out ^ {rcon, 24'h000000};
    else if (nk == 4'd8 && kpos == 4'd4)
      gen = win[0] ^ sub_out;
    else
      gen = win[0] ^ tail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < MAXW; j++) win[j] <= '0;
      nk   <= 4'd4;
      kpos <= 4'd0;
      rcon <= 8'h01;
    end else if (load) begin
      for (int j = 0; j < MAXW; j++) win[j] <= key_in[32*MAXW-1-32*j -: 32];
      nk   <= nk_of(key_len);
      kpos <= 4'd0;
      rcon <= 8'h01;
    end else if (advance) begin
      for (int j = 0; j < MAXW; j++) begin
        if (j == int'(nk) - 1)  win[j] <= gen;
        else if (j < MAXW - 1)  win[j] <= win[j+1];
      end
      kpos <= (kpos == nk - 4'd1) ? 4'd0 : kpos + 4'd1;
      if (kpos == 4'd0) rcon <= xtime(rcon);
    end
  end

  assign word = win[0];
endmodule

// File: rtl/aes_round_seq.sv
`timescale 1ns/1ps
module aes_round_seq #(
  parameter int SUBS  = 1,
  parameter int SUB_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [3:0]       nr_in,
  output logic             busy,
  output logic [SUB_W-1:0] sub,
  output logic [1:0]       col,
  output logic [3:0]       rnd,
  output logic [3:0]       nr,
  output logic             col_end,
  output logic             pass_end,
  output logic             blk_end
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBS - 1);

  assign col_end  = busy && (sub == SUB_LAST);
  assign pass_end = col_end && (col == 2'd3);
  assign blk_end  = pass_end && (rnd == nr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sub  <= '0;
      col  <= 2'd0;
      rnd  <= 4'd0;
      nr   <= 4'd0;
    end else if (go) begin
      busy <= 1'b1;
      sub  <= '0;
      col  <= 2'd0;
      rnd  <= 4'd0;
      nr   <= nr_in;
    end else if (busy) begin
      if (col_end) begin
        sub <= '0;
        col <= col + 2'd1;
        if (pass_end) rnd  <= rnd + 4'd1;
        if (blk_end)  busy <= 1'b0;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aes_slice_enc.sv
`timescale 1ns/1ps
module aes_slice_enc #(
  parameter int LANES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   key_len,
  input  logic [255:0] key,
  input  logic [127:0] pt,
  output logic [127:0] ct,
  output logic         done
);
  import aes_slice_pkg::*;
  localparam int SUBS  = 4 / LANES;
  localparam int SUB_W = (SUBS > 1) ? $clog2(SUBS) : 1;

  // named events used by the checker
  logic             start_take;
  logic             busy, col_end, pass_end, blk_end;
  logic [SUB_W-1:0] sub;
  logic [1:0]       col;
  logic [3:0]       rnd, nr;
  logic             first_pass, mix_on;
  logic [31:0]      rk_word;

  logic [31:0] st_col [4];
  logic [31:0] nx_col [4];
  logic [7:0]  hold_b [4];
  logic [7:0]  asm_b  [4];
  logic [7:0]  lane_src [LANES];
  logic [7:0]  lane_sub [LANES];
  logic [7:0]  lane_val [LANES];
  logic [31:0] asm_w, col_res;

  assign start_take = start && !busy;
  assign first_pass = (rnd == 4'd0);
  assign mix_on     = !first_pass && (rnd != nr);

  aes_round_seq #(.SUBS(SUBS), .SUB_W(SUB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(start_take), .nr_in(nr_of(key_len)),
    .busy(busy), .sub(sub), .col(col), .rnd(rnd), .nr(nr),
    .col_end(col_end), .pass_end(pass_end), .blk_end(blk_end)
  );

  aes_key_sched #(.MAXW(8)) u_ksched (
    .clk(clk), .rst_n(rst_n), .load(start_take), .key_in(key),
    .key_len(key_len), .advance(col_end), .word(rk_word)
  );

  // byte lanes: row shift is a read-index remap, then substitution
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [1:0] row, scol;
    assign row  = 2'(int'(sub) * LANES + l);
    assign scol = first_pass ? col : col + row;
    assign lane_src[l] = byte_of(st_col[scol], row);
    aes_sbox u_sbox (.din(lane_src[l]), .dout(lane_sub[l]));
    assign lane_val[l] = first_pass ? lane_src[l] : lane_sub[l];
  end

  always_comb begin
    for (int r = 0; r < 4; r++) begin
      if (r / LANES == int'(sub)) asm_b[r] = lane_val[r % LANES];
      else                        asm_b[r] = hold_b[r];
    end
  end

  assign asm_w   = {asm_b[0], asm_b[1], asm_b[2], asm_b[3]};
  assign col_res = (mix_on ? mix_col(asm_w) : asm_w) ^ rk_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        st_col[c] <= '0;
        nx_col[c] <= '0;
        hold_b[c] <= '0;
      end
      done <= 1'b0;
    end else begin
      done <= blk_end;
      if (start_take) begin
        for (int c = 0; c < 4; c++) st_col[c] <= pt[127-32*c -: 32];
      end else if (col_end) begin
        nx_col[col] <= col_res;
        if (pass_end) begin
          for (int c = 0; c < 3; c++) st_col[c] <= nx_col[c];
          st_col[3] <= col_res;
        end
      end
      if (busy) begin
        for (int c = 0; c < 4; c++) hold_b[c] <= asm_b[c];
      end
    end
  end

  assign ct = {st_col[0], st_col[1], st_col[2], st_col[3]};
endmodule

// File: rtl/aes_slice_enc_chk.sv
`timescale 1ns/1ps
module aes_slice_enc_chk #(
  parameter int LANES = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic         busy,
  input logic         blk_end,
  input logic [3:0]   rnd,
  input logic [3:0]   nr,
  input logic [127:0] ct
);
  logic [9:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lat <= '0;
    else if (start && !busy)  lat <= '0;
    else if (busy)            lat <= lat + 10'd1;
  end

  // R6: done arrives after exactly (Nr+1)*16/LANES busy edges
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(lat) == (int'(nr) + 1) * 16 / LANES));

  // R7: single-cycle done
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: idle output is held
  a_r8_ct_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(ct));

  // R9: a start while busy does not restart the round count
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !blk_end) |=> (busy && rnd >= $past(rnd)));

  // R2: round index never passes the key-size round count
  a_r2_round_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rnd <= nr));
endmodule

bind aes_slice_enc aes_slice_enc_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
  .blk_end(blk_end), .rnd(rnd), .nr(nr), .ct(ct)
);

// File: tb/aes_slice_enc_bench.sv
`timescale 1ns/1ps
module aes_slice_enc_bench;
  logic         clk = 1'b0;
  logic         rst_n, start;
  logic [1:0]   key_len;
  logic [255:0] key;
  logic [127:0] pt;
  logic [127:0] ct4, ct2;
  logic         done4, done2;
  int           n_chk, n_err;
  logic [7:0]   sbt [256];

  always #2.5 clk = ~clk;

  aes_slice_enc #(.LANES(4)) u_aes_slice_enc (
    .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len), .key(key),
    .pt(pt), .ct(ct4), .done(done4));

  aes_slice_enc #(.LANES(2)) u_aes_slice_enc_p2 (
    .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len), .key(key),
    .pt(pt), .ct(ct2), .done(done2));

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rl(input logic [7:0] v, input int s);
    return (v << s) | (v >> (8 - s));
  endfunction

  function automatic logic [7:0] xt(input logic [7:0] v);
    return (v << 1) ^ (v[7] ? 8'h1B : 8'h00);
  endfunction

  // S-box table from a walk over the multiplicative group (generator 3)
  task automatic build_sbox();
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sbt[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sbt[0] = 8'h63;
  endtask

  function automatic logic [127:0] ref_enc(input logic [255:0] k, input logic [1:0] kl,
                                           input logic [127:0] p);
    int nk, nr;
    logic [7:0] w [240];
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] tmp [4];
    logic [7:0] sv, rc;
    logic [127:0] res;
    nk = (kl == 2'b00) ? 4 : (kl == 2'b01) ? 6 : 8;
    nr = nk + 6;
    for (int i = 0; i < 4*nk; i++) w[i] = k[255-8*i -: 8];
    rc = 8'h01;
    for (int i = nk; i < 4*(nr+1); i++) begin
      for (int b = 0; b < 4; b++) tmp[b] = w[4*(i-1)+b];
      if (i % nk == 0) begin
        sv = tmp[0];
        tmp[0] = sbt[tmp[1]] ^ rc; tmp[1] = sbt[tmp[2]];
        tmp[2] = sbt[tmp[3]];      tmp[3] = sbt[sv];
        rc = xt(rc);
      end else if (nk == 8 && i % nk == 4) begin
        for (int b = 0; b < 4; b++) tmp[b] = sbt[tmp[b]];
      end
      for (int b = 0; b < 4; b++) w[4*i+b] = w[4*(i-nk)+b] ^ tmp[b];
    end
    for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i];
    for (int rd = 1; rd <= nr; rd++) begin
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[r+4*c] = sbt[s[r + 4*((c+r)%4)]];
      for (int c = 0; c < 4; c++) begin
        if (rd < nr) begin
          s[4*c+0] = xt(t[4*c]) ^ xt(t[4*c+1]) ^ t[4*c+1] ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ xt(t[4*c+1]) ^ xt(t[4*c+2]) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ xt(t[4*c+2]) ^ xt(t[4*c+3]) ^ t[4*c+3];
          s[4*c+3] = xt(t[4*c]) ^ t[4*c] ^ t[4*c+1] ^ t[4*c+2] ^ xt(t[4*c+3]);
        end else begin
          for (int r = 0; r < 4; r++) s[4*c+r] = t[4*c+r];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[16*rd + i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  // Runs one block on both instances; done is seen at falling edge
  // index (Nr+1)*16/LANES + 1 counted from the falling edge that drove start.
  task automatic run_block(input logic [255:0] k, input logic [1:0] kl,
                           input logic [127:0] p, input logic [127:0] exp,
                           input string req, input bit poke);
    int nr, e4, e2, f4, f2, c4, c2;
    logic [127:0] g4, g2;
    nr = (kl == 2'b00) ? 10 : (kl == 2'b01) ? 12 : 14;
    e4 = (nr + 1) * 4 + 1;
    e2 = (nr + 1) * 8 + 1;
    f4 = -1; f2 = -1; c4 = 0; c2 = 0; g4 = '0; g2 = '0;
    @(negedge clk);
    key = k; key_len = kl; pt = p; start = 1'b1;
    for (int n = 1; n <= e2 + 2; n++) begin
      @(negedge clk);
      if (done4) begin c4++; if (f4 < 0) begin f4 = n; g4 = ct4; end end
      if (done2) begin c2++; if (f2 < 0) begin f2 = n; g2 = ct2; end end
      start = 1'b0;
      if (poke && n == 4) begin
        start = 1'b1; pt = ~p; key = ~k; key_len = 2'b10;
      end
    end
    chk(g4 === exp, {req, " P=4 ciphertext"}, g4, exp);
    chk(g2 === exp, {req, " P=2 ciphertext (R10)"}, g2, exp);
    chk(f4 == e4, "R6 P=4 latency", 128'(f4), 128'(e4));
    chk(f2 == e2, "R6 P=2 latency", 128'(f2), 128'(e2));
    chk(c4 == 1 && c2 == 1, "R7 done pulse count", 128'({c4, c2}), 128'({32'd1, 32'd1}));
    repeat (3) @(negedge clk);
    chk(ct4 === exp && ct2 === exp, "R8 idle hold", ct2, exp);
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [255:0] k;
    logic [127:0] p;
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; start = 1'b0; key_len = 2'b00; key = '0; pt = '0;
    build_sbox();
    repeat (3) @(negedge clk);
    chk(ct4 === '0 && ct2 === '0, "R1 reset ct", ct4, '0);
    chk(done4 === 1'b0 && done2 === 1'b0, "R1 reset done", 128'({done4, done2}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4: byte order and 128-bit known answers; low key bits are junk (R2)
    run_block({128'h000102030405060708090a0b0c0d0e0f, 128'h5a5a_1234_dead_beef_0f0f_f0f0_a5a5_c3c3},
              2'b00, 128'h00112233445566778899aabbccddeeff,
              128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 R3", 1'b0);
    run_block({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0},
              2'b00, 128'h3243f6a8885a308d313198a2e0370734,
              128'h3925841d02dc09fbdc118597196a0b32, "R4", 1'b0);
    run_block(256'h0, 2'b00, 128'h0,
              128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R4 zero", 1'b0);
    // R5: 192- and 256-bit known answers
    run_block({192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'hfeedface_cafef00d},
              2'b01, 128'h00112233445566778899aabbccddeeff,
              128'hdda97ca4864cdfe06eaf70a0ec0d7191, "R5 192 R2", 1'b0);
    run_block(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
              2'b10, 128'h00112233445566778899aabbccddeeff,
              128'h8ea2b7ca516745bfeafc49904b496089, "R5 256", 1'b0);
    // R2: code 11 behaves as a 256-bit key
    run_block(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
              2'b11, 128'h00112233445566778899aabbccddeeff,
              128'h8ea2b7ca516745bfeafc49904b496089, "R2 code 11", 1'b0);

    // R5: sweep of keys and blocks for every key size against the model
    for (int kl = 0; kl < 3; kl++) begin
      for (int b = 0; b < 6; b++) begin
        k = rnd256();
        p = {$urandom(), $urandom(), $urandom(), $urandom()};
        run_block(k, 2'(kl), p, ref_enc(k, 2'(kl), p), "R5 sweep", 1'b0);
      end
    end

    // R9: start with other data while busy is ignored
    k = rnd256();
    p = {$urandom(), $urandom(), $urandom(), $urandom()};
    run_block(k, 2'b01, p, ref_enc(k, 2'b01, p), "R9 busy start", 1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule